// File: doc/BRIEF.md
# Stereo Serial Audio Port with Mixed Justification

This block is the digital serial port of a stereo codec that runs as a slave to an external bit clock and word clock. On the playback side it deserialises right-justified 16-bit samples from the serial input and hands each left and right pair to the core in parallel, with a one-cycle strobe. On the capture side it takes parallel left and right samples from the core and drives them out left-justified, MSB first, on the same clocks.

The bit clock, word clock and serial input are brought into the fast system clock domain through synchronisers. All later logic acts on edge strobes derived from those synchronised copies. The frame length is not configured: the port works with 32, 48 or 64 bit clocks per word-clock period. It does this by taking the trailing 16 bits of each half-frame on receive, and by padding with zeros after the 16th bit on transmit. While the capture path is not enabled, every transmitted word is zero.

Top module: `jus_audio_port`

## Requirements
- R1: After reset `rxValid`, `sdout`, `rxLeft` and `rxRight` are all 0.
- R2: On receive, `sdin` is sampled at each rising bit-clock edge. The channel word is the last 16 bits sampled before the word clock changes level, MSB first. Any earlier bits of that half-frame are ignored.
- R3: Word clock high marks the left channel and low marks the right channel, with left first in a frame. The pair is presented one system cycle after the first rising bit-clock edge that sees the word clock high again. `rxValid` is high for exactly one system cycle.
- R4: Frames of 32, 48 and 64 bit clocks (16, 24 and 32 per half) are all received and transmitted correctly, with no configuration.
- R5: On transmit, the MSB of the channel word is driven in the first bit slot after a word-clock edge, followed by the other 15 bits in order. Every later slot of that half-frame carries 0.
- R6: `sdout` changes only in the system cycle after a synchronised falling bit-clock edge or word-clock edge. It is stable while the bit clock is high.
- R7: If `capEnable` is low when a word starts, that whole word is transmitted as zeros.
- R8: If either half of a frame has fewer than 16 rising bit-clock edges, no pair is presented for that frame, and reception recovers on the next full frame.
- R9: `txLeft` is captured at the word-clock rising edge and `txRight` at its falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock from the external master |
| wclk | input | 1 | Word clock: high = left, low = right |
| sdin | input | 1 | Playback serial data, right-justified |
| capEnable | input | 1 | Capture path enabled; when low, zero words are sent |
| txLeft | input | 16 | Left capture sample to transmit |
| txRight | input | 16 | Right capture sample to transmit |
| sdout | output | 1 | Capture serial data, left-justified |
| rxLeft | output | 16 | Last received left sample |
| rxRight | output | 16 | Last received right sample |
| rxValid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The hardest case to reach from the ports is a word-clock edge that arrives in the same synchronised cycle as a falling bit-clock edge. The transmitter must give that edge priority and load the new MSB rather than shift the old word. The stimulus makes this happen on every half-frame by switching the word clock together with the bit-clock fall, and it fills the unused leading receive slots with ones so that a wrong window shows up. A short half-frame is injected after the table of frames, so the bench can observe that a pair is dropped and that reception recovers.

// File: rtl/jap_pkg.sv
package jap_pkg;
  // Edge strobes and synchronised levels passed from control to datapath
  typedef struct packed {
    logic bRise;
    logic bFall;
    logic wEdge;
    logic wNow;
    logic rxBit;
  } strobe_t;
endpackage

// File: rtl/jap_sync_ctrl.sv
module jap_sync_ctrl
  import jap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    bclk,
  input  logic    wclk,
  input  logic    sdin,
  output strobe_t st
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] bSync, wSync, dSync;
  logic bPrev, wPrev;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bSync <= '0; wSync <= '0; dSync <= '0;
        end else begin
          bSync <= bclk; wSync <= wclk; dSync <= sdin;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bSync <= '0; wSync <= '0; dSync <= '0;
        end else begin
          bSync <= {bSync[TOP-1:0], bclk};
          wSync <= {wSync[TOP-1:0], wclk};
          dSync <= {dSync[TOP-1:0], sdin};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bPrev <= 1'b0;
      wPrev <= 1'b0;
    end else begin
      bPrev <= bSync[TOP];
      wPrev <= wSync[TOP];
    end
  end

  always_comb begin
    st.bRise = bSync[TOP] & ~bPrev;
    st.bFall = ~bSync[TOP] & bPrev;
    st.wEdge = wSync[TOP] ^ wPrev;
    st.wNow  = wSync[TOP];
    st.rxBit = dSync[TOP];
  end
endmodule

// File: rtl/jap_datapath.sv
module jap_datapath
  import jap_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int MAX_HALF = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             st,
  input  logic                capEnable,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic                sdout,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxValid
);
  localparam int CNT_W = $clog2(MAX_HALF + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'((1 << CNT_W) - 1);
  localparam logic [CNT_W-1:0] CNT_NEED = CNT_W'(SAMPLE_W);

  // receive side
  logic [SAMPLE_W-1:0] rxShift, leftHold;
  logic [CNT_W-1:0]    bitCnt;
  logic                lastLevel, leftOk;
  logic                halfFull;

  assign halfFull = (bitCnt >= CNT_NEED);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      leftHold  <= '0;
      bitCnt    <= '0;
      lastLevel <= 1'b0;
      leftOk    <= 1'b0;
      rxLeft    <= '0;
      rxRight   <= '0;
      rxValid   <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (st.bRise) begin
        if (st.wNow != lastLevel) begin
          // the previous half-frame just ended; its window is in rxShift
          if (lastLevel) begin
            leftHold <= rxShift;
            leftOk   <= halfFull;
          end else begin
            if (leftOk && halfFull) begin
              rxLeft  <= leftHold;
              rxRight <= rxShift;
              rxValid <= 1'b1;
            end
            leftOk <= 1'b0;
          end
          bitCnt <= CNT_W'(1);
        end else if (bitCnt != CNT_MAX) begin
          bitCnt <= bitCnt + 1'b1;
        end
        rxShift   <= {rxShift[SAMPLE_W-2:0], st.rxBit};
        lastLevel <= st.wNow;
      end
    end
  end

  // transmit side
  logic [SAMPLE_W-1:0] txShift, txNext;
  logic                sdoutR;

  always_comb begin
    if (!capEnable)   txNext = '0;
    else if (st.wNow) txNext = txLeft;
    else              txNext = txRight;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      sdoutR  <= 1'b0;
    end else if (st.wEdge) begin
      // a word-clock edge wins over a simultaneous bit-clock fall
      sdoutR  <= txNext[SAMPLE_W-1];
      txShift <= {txNext[SAMPLE_W-2:0], 1'b0};
    end else if (st.bFall) begin
      sdoutR  <= txShift[SAMPLE_W-1];
      txShift <= {txShift[SAMPLE_W-2:0], 1'b0};
    end
  end

  assign sdout = sdoutR;
endmodule

// File: rtl/jus_audio_port.sv
module jus_audio_port
  import jap_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int MAX_HALF    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bclk,
  input  logic                wclk,
  input  logic                sdin,
  input  logic                capEnable,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic                sdout,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxValid
);
  strobe_t strb;

  jap_sync_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .bclk(bclk), .wclk(wclk), .sdin(sdin), .st(strb)
  );

  jap_datapath #(.SAMPLE_W(SAMPLE_W), .MAX_HALF(MAX_HALF)) u_data (
    .clk(clk), .rstN(rstN), .st(strb), .capEnable(capEnable),
    .txLeft(txLeft), .txRight(txRight), .sdout(sdout),
    .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid)
  );
endmodule

// File: rtl/jap_check.sv
module jap_check
  import jap_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input strobe_t st,
  input logic    sdout,
  input logic    rxValid
);
  // R1: outputs are quiet on the first cycle out of reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!rxValid && !sdout));

  // R3: the pair strobe lasts one cycle
  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R3: a pair is presented only after a rising bit clock that saw the left level
  p_valid_after_left_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ($past(st.bRise) && $past(st.wNow)));

  // R6: serial output moves only after a bit-clock fall or word-clock edge
  p_sdout_timing_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdout) |-> $past(st.bFall || st.wEdge));
endmodule

bind jus_audio_port jap_check u_chk (
  .clk(clk), .rstN(rstN), .st(strb), .sdout(sdout), .rxValid(rxValid)
);

// File: tb/sim_jus_audio_port.sv
module sim_jus_audio_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bclk = 1'b1, wclk = 1'b0, sdin = 1'b0, capEnable = 1'b1;
  logic [15:0] txLeft = '0, txRight = '0;
  logic sdout, rxValid;
  logic [15:0] rxLeft, rxRight;

  int total = 0, bad = 0;
  int pairs = 0;
  logic [15:0] gotL = '0, gotR = '0;

  always #5 clk = ~clk;

  jus_audio_port u0 (
    .clk(clk), .rstN(rstN), .bclk(bclk), .wclk(wclk), .sdin(sdin),
    .capEnable(capEnable), .txLeft(txLeft), .txRight(txRight),
    .sdout(sdout), .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid)
  );

  always @(negedge clk) if (rxValid) begin
    pairs++;
    gotL = rxLeft;
    gotR = rxRight;
  end

  localparam int NV = 6;
  localparam int           V_HALF [NV] = '{32, 24, 16, 32, 16, 24};
  localparam logic [15:0]  V_RXL  [NV] = '{16'hA5C3, 16'h8001, 16'h1234, 16'hFFFF, 16'h0F0F, 16'h7FFE};
  localparam logic [15:0]  V_RXR  [NV] = '{16'h5A3C, 16'h0000, 16'hFEDC, 16'h0001, 16'hC0DE, 16'h8000};
  localparam logic [15:0]  V_TXL  [NV] = '{16'hBEEF, 16'h0001, 16'h8000, 16'h1357, 16'hAAAA, 16'h6C6C};
  localparam logic [15:0]  V_TXR  [NV] = '{16'h4321, 16'hFFFE, 16'h7FFF, 16'h2468, 16'h5555, 16'h9393};
  localparam bit           V_CAP  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One half-frame: drives right-justified sdin (leading pad of ones),
  // and samples sdout just before each rising bit-clock edge.
  task automatic playHalf(input int n, input logic lvl, input logic [15:0] rxw,
                          input logic [15:0] expTx, input bit chkTx);
    logic [15:0] capt = '0;
    bit padErr = 0, moveErr = 0;
    for (int i = 0; i < n; i++) begin
      logic got;
      bclk = 1'b0;
      if (i == 0) wclk = lvl;
      sdin = (n - 1 - i < 16) ? rxw[n-1-i] : 1'b1;
      repeat (8) @(negedge clk);
      got = sdout;
      if (i < 16) capt[15-i] = got;
      else if (got !== 1'b0) padErr = 1;
      bclk = 1'b1;
      repeat (8) @(negedge clk);
      if (sdout !== got) moveErr = 1;
    end
    if (chkTx) begin
      // R5 R7 R9: left-justified word, MSB first
      check(capt === expTx, lvl ? "R5/R9 left tx word" : "R5/R9 right tx word", capt, expTx);
      check(!padErr, "R5 zero after 16th slot", padErr, 0);
      check(!moveErr, "R6 sdout stable while bclk high", moveErr, 0);
    end
  endtask

  task automatic playFrame(input int n, input logic [15:0] rl, input logic [15:0] rr,
                           input logic [15:0] tl, input logic [15:0] tr, input bit cap,
                           input bit chkTx);
    txLeft = tl; txRight = tr; capEnable = cap;
    playHalf(n, 1'b1, rl, cap ? tl : 16'h0, chkTx);
    playHalf(n, 1'b0, rr, cap ? tr : 16'h0, chkTx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(rxValid === 1'b0, "R1 rxValid in reset", rxValid, 0);
    check(sdout === 1'b0, "R1 sdout in reset", sdout, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(rxValid === 1'b0 && sdout === 1'b0, "R1 quiet after reset", {rxValid, sdout}, 0);
    check(rxLeft === 16'h0 && rxRight === 16'h0, "R1 rx words zero", {rxLeft, rxRight}, 0);

    // Table of frames: R2 R3 R4 (all three frame lengths), R7 in row 3
    for (int k = 0; k < NV; k++) begin
      playFrame(V_HALF[k], V_RXL[k], V_RXR[k], V_TXL[k], V_TXR[k], V_CAP[k], 1'b1);
      if (k > 0) begin
        check(pairs == k, "R3 one strobe per frame", pairs, k);
        check(gotL === V_RXL[k-1], "R2/R4 rx left", gotL, V_RXL[k-1]);
        check(gotR === V_RXR[k-1], "R2/R4 rx right", gotR, V_RXR[k-1]);
      end
    end

    // R8: short frame (8 bits per half) produces no pair
    playFrame(8, 16'h00AA, 16'h0055, 16'h1111, 16'h2222, 1'b1, 1'b0);
    check(pairs == NV, "R3 last table pair", pairs, NV);
    check(gotL === V_RXL[NV-1] && gotR === V_RXR[NV-1], "R2 last table words",
          {gotL, gotR}, {V_RXL[NV-1], V_RXR[NV-1]});
    playFrame(32, 16'h3C3C, 16'hC3C3, 16'hD00D, 16'h0BB0, 1'b1, 1'b1);
    check(pairs == NV, "R8 short frame dropped", pairs, NV);
    playFrame(16, 16'h9999, 16'h6666, 16'hF00F, 16'h0FF0, 1'b1, 1'b1);
    check(pairs == NV + 1, "R8 recovery count", pairs, NV + 1);
    check(gotL === 16'h3C3C && gotR === 16'hC3C3, "R8 recovery words",
          {gotL, gotR}, {16'h3C3C, 16'hC3C3});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule